// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the program counter of a small core whose instructions are 14 bits wide, and it chooses the next fetch address in every instruction cycle. The counter is 13 bits, so it spans 8K words. Only the lowest 1K words of program store are built, so the block also presents a 10-bit physical fetch address. Any counter value above 03FFh therefore folds back onto the built region.

The decoder in front of the block supplies control strobes that are already decoded: an instruction-cycle enable, interrupt entry, jump, call and return, plus a 13-bit target. The three return flavours (plain return, return from interrupt and return with a literal) all drive the same return strobe, because they move the counter in the same way.

Return addresses are kept in a private eight-level circular stack. The stack has no overflow or underflow indication. Reset loads 0000h. Interrupt entry saves the address it pre-empts and then loads 0004h.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes 0000h and the stack pointer and every stack entry become zero. A return issued right after reset therefore yields 0000h, even if the stack held data before the reset.
- R2: When `cyc_en` is high and no strobe is active, the counter advances by one per clock. It wraps from 1FFFh to 0000h.
- R3: `fetch_addr` always equals bits 9:0 of `pc`. For example, 1FFFh gives 3FFh and 0C05h gives 005h.
- R4: A jump loads `tgt` into the counter and leaves the stack unchanged.
- R5: A call loads `tgt` into the counter and pushes the call's own address plus one.
- R6: A return loads the counter from the most recently pushed entry and removes that entry from the stack.
- R7: Interrupt entry loads 0004h into the counter and pushes the current counter value, which is the address of the instruction it pre-empts.
- R8: The strobes are resolved in a fixed priority order: reset first, then interrupt entry, then return, then call, then jump.
- R9: With `cyc_en` low and `rst` low, the counter and the stack hold their values, and every other strobe is ignored.
- R10: The stack has eight entries and is circular. A ninth push overwrites the oldest entry. Popping beyond the oldest live entry returns whatever entry the pointer wraps onto. No flag is raised in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction cycle enable |
| irq_take | input | 1 | Interrupt entry strobe |
| ret_en | input | 1 | Return strobe shared by all return flavours |
| call_en | input | 1 | Call strobe |
| jump_en | input | 1 | Absolute jump strobe |
| tgt | input | 13 | Target address for jump or call |
| pc | output | 13 | Full program counter |
| fetch_addr | output | 10 | Physical program-store address |

## Verification
Interrupt entry can land in the same cycle as a decoded jump or call, and reset can land together with a call. The bench raises each pair together in a single cycle. It then judges the result by the new counter value. Where the outcome depends on it, it also issues a later return to show which address, if any, went onto the stack: the pre-empted address for an interrupt, and nothing at all for a call that lost to reset.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int          PC_BITS    = 13;
    localparam int          PHYS_BITS  = 10;
    localparam int          STK_LEVELS = 8;
    localparam logic [12:0] VEC_RESET  = 13'h0000;
    localparam logic [12:0] VEC_IRQ    = 13'h0004;

    // Resolved action for one instruction cycle
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_JUMP,
        OP_CALL,
        OP_RET,
        OP_IRQ,
        OP_RESET
    } pc_op_e;

    typedef struct packed {
        logic cyc;
        logic irq;
        logic ret;
        logic call;
        logic jump;
    } strobe_t;

    // Fixed priority: reset, interrupt, return, call, jump, increment
    function automatic pc_op_e pick_op(input logic rst, input strobe_t s);
        if (rst)         return OP_RESET;
        else if (!s.cyc) return OP_HOLD;
        else if (s.irq)  return OP_IRQ;
        else if (s.ret)  return OP_RET;
        else if (s.call) return OP_CALL;
        else if (s.jump) return OP_JUMP;
        else             return OP_INC;
    endfunction

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
    import pcseq_pkg::*;
(
    input  logic    rst,
    input  strobe_t strobes,
    output pc_op_e  op,
    output logic    push,
    output logic    pop,
    output logic    save_cur
);
    always_comb begin
        op       = pick_op(rst, strobes);
        push     = (op == OP_CALL) || (op == OP_IRQ);
        pop      = (op == OP_RET);
        save_cur = (op == OP_IRQ);
    end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] rd_idx;
    logic [W-1:0]     slot [DEPTH];

    // Pointer wraps modulo DEPTH; no overflow or underflow detection
    always_ff @(posedge clk) begin
        if (rst)       sp <= '0;
        else if (push) sp <= sp + PTR_W'(1);
        else if (pop)  sp <= sp - PTR_W'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (push && (sp == PTR_W'(i)))
                slot[i] <= push_val;
        end
    end

    assign rd_idx  = sp - PTR_W'(1);
    assign top_val = slot[rd_idx];
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int           W       = 13,
    parameter logic [W-1:0] RST_VEC = '0,
    parameter logic [W-1:0] IRQ_VEC = W'(4)
) (
    input  pc_op_e       op,
    input  logic [W-1:0] pc_cur,
    input  logic [W-1:0] tgt,
    input  logic [W-1:0] stack_top,
    output logic [W-1:0] pc_nxt
);
    always_comb begin
        unique case (op)
            OP_RESET: pc_nxt = RST_VEC;
            OP_IRQ:   pc_nxt = IRQ_VEC;
            OP_RET:   pc_nxt = stack_top;
            OP_CALL,
            OP_JUMP:  pc_nxt = tgt;
            OP_INC:   pc_nxt = pc_cur + W'(1);
            default:  pc_nxt = pc_cur;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int                PC_W    = PC_BITS,
    parameter int                PHYS_W  = PHYS_BITS,
    parameter int                DEPTH   = STK_LEVELS,
    parameter logic [PC_W-1:0]   RST_VEC = PC_W'(VEC_RESET),
    parameter logic [PC_W-1:0]   IRQ_VEC = PC_W'(VEC_IRQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en,
    input  logic              irq_take,
    input  logic              ret_en,
    input  logic              call_en,
    input  logic              jump_en,
    input  logic [PC_W-1:0]   tgt,
    output logic [PC_W-1:0]   pc,
    output logic [PHYS_W-1:0] fetch_addr
);
    strobe_t         strobes;
    pc_op_e          op;
    logic            push;
    logic            pop;
    logic            save_cur;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] push_val;
    logic [PC_W-1:0] stack_top;

    assign strobes = '{cyc: cyc_en, irq: irq_take, ret: ret_en,
                       call: call_en, jump: jump_en};

    pcseq_ctrl u_ctrl (
        .rst      (rst),
        .strobes  (strobes),
        .op       (op),
        .push     (push),
        .pop      (pop),
        .save_cur (save_cur)
    );

    // Interrupt saves the pre-empted address, call saves the following one
    assign push_val = save_cur ? pc_q : (pc_q + PC_W'(1));

    pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .top_val  (stack_top)
    );

    pcseq_next #(.W(PC_W), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)) u_next (
        .op        (op),
        .pc_cur    (pc_q),
        .tgt       (tgt),
        .stack_top (stack_top),
        .pc_nxt    (pc_nxt)
    );

    always_ff @(posedge clk) begin
        pc_q <= pc_nxt;
    end

    assign pc         = pc_q;
    assign fetch_addr = pc_q[PHYS_W-1:0];
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int              PC_W    = 13,
    parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4)
) (
    input logic            clk,
    input logic            rst,
    input logic            cyc_en,
    input logic            irq_take,
    input logic            ret_en,
    input logic            call_en,
    input logic            jump_en,
    input logic [PC_W-1:0] tgt,
    input logic [PC_W-1:0] pc
);
    // R2
    seq_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && !irq_take && !ret_en && !call_en && !jump_en)
        |=> (pc == PC_W'($past(pc) + PC_W'(1))));

    // R4
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && jump_en && !irq_take && !ret_en && !call_en)
        |=> (pc == $past(tgt)));

    // R5
    call_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && call_en && !irq_take && !ret_en)
        |=> (pc == $past(tgt)));

    // R7
    irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && irq_take) |=> (pc == IRQ_VEC));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> $stable(pc));
endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_en   (cyc_en),
    .irq_take (irq_take),
    .ret_en   (ret_en),
    .call_en  (call_en),
    .jump_en  (jump_en),
    .tgt      (tgt),
    .pc       (pc)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_en = 1'b0, irq_take = 1'b0, ret_en = 1'b0;
    logic        call_en = 1'b0, jump_en = 1'b0;
    logic [12:0] tgt = '0;
    logic [12:0] pc;
    logic [9:0]  fetch_addr;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .irq_take(irq_take),
        .ret_en(ret_en), .call_en(call_en), .jump_en(jump_en),
        .tgt(tgt), .pc(pc), .fetch_addr(fetch_addr)
    );

    // cyc, irq, ret, call, jump, target, expected pc
    typedef struct packed {
        logic        c, i, r, k, j;
        logic [12:0] t;
        logic [12:0] e;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 13'h0000, 13'h0001}, // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 13'h0000, 13'h0002}, // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b1, 13'h0100, 13'h0100}, // R4
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 13'h0200, 13'h0200}, // R5 push 101
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 13'h0000, 13'h0201}, // R2
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 13'h0300, 13'h0300}, // R5 push 202
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 13'h0000, 13'h0202}, // R6
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 13'h0000, 13'h0101}, // R6
        '{1'b1,1'b1,1'b0,1'b0,1'b1, 13'h0050, 13'h0004}, // R7 R8 push 101
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 13'h0000, 13'h0101}, // R7 pre-empted addr
        '{1'b1,1'b0,1'b0,1'b0,1'b1, 13'h1FFF, 13'h1FFF}, // R3 fold
        '{1'b1,1'b0,1'b0,1'b0,1'b0, 13'h0000, 13'h0000}, // R2 wrap
        '{1'b1,1'b0,1'b0,1'b0,1'b1, 13'h0C05, 13'h0C05}, // R3 fold
        '{1'b0,1'b0,1'b0,1'b0,1'b1, 13'h0010, 13'h0C05}, // R9
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 13'h0040, 13'h0040}, // R8 call over jump
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 13'h0000, 13'h0C06}, // R6
        '{1'b1,1'b1,1'b0,1'b1,1'b0, 13'h0077, 13'h0004}, // R8 irq over call
        '{1'b1,1'b0,1'b1,1'b0,1'b0, 13'h0000, 13'h0C06}  // R7 R8
    };

    task automatic drive(input logic r, c, i, rt, k, j, input logic [12:0] t);
        rst = r; cyc_en = c; irq_take = i; ret_en = rt; call_en = k;
        jump_en = j; tgt = t;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [12:0] exp_pc);
        n_run++;
        if (pc !== exp_pc || fetch_addr !== exp_pc[9:0]) begin
            n_fail++;
            $display("FAIL %s: pc=%h fetch=%h expected pc=%h fetch=%h",
                     req, pc, fetch_addr, exp_pc, exp_pc[9:0]);
        end
    endtask

    initial begin
        logic [12:0] pushed [9];
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 13'h0123);
        check("R1 reset state", 13'h0000);

        for (int v = 0; v < NV; v++) begin
            drive(1'b0, TBL[v].c, TBL[v].i, TBL[v].r, TBL[v].k, TBL[v].j, TBL[v].t);
            check($sformatf("R2/R3/R4/R5/R6/R7/R8/R9 vector %0d", v), TBL[v].e);
        end

        // R1 R8: reset beats a simultaneous call, clears the pointer
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 13'h0123);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'h0200);
        check("R5 call before reset", 13'h0200);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'h0055);
        check("R1 R8 reset over call", 13'h0000);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 13'h0000);
        check("R1 stack cleared by reset", 13'h0000);

        // R10: nine pushes into eight levels, then nine pops
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0000);
        for (int k = 1; k <= 9; k++) begin
            pushed[k-1] = 13'(16 * (k - 1) + 1);
            drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'(16 * k));
            check("R10 deep call", 13'(16 * k));
        end
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 13'h0000);
            check("R10 pop order", pushed[8 - k]);
        end
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 13'h0000);
        check("R10 pop wraps to overwritten slot", pushed[8]);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule